// File: doc/BRIEF.md
# H-Bridge Gate Control Sequencer

This block is the digital core of a full-bridge gate driver. Three logic inputs select the bridge state: a drive command (`pwmHi`), a recirculation command (`pwmLo`) and a synchronous-rectification enable (`syncRect`). The block turns them into four gate enables, one high-side and one low-side for each of the two legs. Leg A is the leg that sources current in the drive state, and leg B is the leg that sinks it. The decode covers drive, coast, and braking on either rail. Each brake can be two-sided, with both FETs on that rail conducting, or one-sided, where one FET conducts and the opposite FET's body diode carries the return current.

Whenever the selection of a leg changes, the leg is held fully off for a programmable dead time before the new FET is enabled. Each FET has a drain-source comparator input. That input is ignored for a blanking window after the FET turns on. A hit seen after the window latches a short fault and removes all gate drive. A separate input turns short detection off entirely.

A control input, `ctrlResetN`, is active low and qualified by how long it is held low. A brief low pulse clears a latched fault. A pulse of middle length does nothing. A long hold puts the block to sleep, which also clears the fault. After sleep, and after power-up, all gates stay off until a supply-settling wait has elapsed. A two-bit flag reports the state. All times are parameters counted in clock cycles.

Top module: `hbridge_gate_seq`

## Requirements
- R1: With `pwmHi`=1 and `pwmLo`=1, the bridge drives: leg A high-side and leg B low-side are on, whatever `syncRect` is.
- R2: With `pwmHi`=0 and `pwmLo`=0, all four gates are off (coast), whatever `syncRect` is.
- R3: With `pwmHi`=0, `pwmLo`=1 and `syncRect`=1, both low-side FETs are on and both high-side FETs are off (two-sided brake).
- R4: With `pwmHi`=0, `pwmLo`=1 and `syncRect`=0, only the leg B low-side FET is on (one-sided brake).
- R5: With `pwmHi`=1 and `pwmLo`=0, braking moves to the high side. With `syncRect`=1 both high-side FETs are on. With `syncRect`=0 only the leg A high-side FET is on.
- R6: Take the first clock edge at which a leg's decoded selection differs from what it applies. At that edge the leg turns fully off. The new FET turns on at the DEAD_CYC-th edge after it. A leg whose selection does not change is undisturbed.
- R7: Bit order of `vdsFault` is [0] leg A high, [1] leg A low, [2] leg B high, [3] leg B low. A FET's `vdsFault` bit is ignored while the FET is off and during its first BLANK_CYC cycles on. A hit after that window latches a short fault one edge later, and all gates go off at once.
- R8: While `shortDetectOff`=1, `vdsFault` never latches a fault.
- R9: A low pulse on `ctrlResetN` of 1 to CLEAR_MAX_CYC sampled cycles clears a latched fault at the edge that samples it high again.
- R10: A low pulse longer than CLEAR_MAX_CYC but shorter than SLEEP_CYC sampled cycles leaves a latched fault in place.
- R11: `ctrlResetN` sampled low for SLEEP_CYC cycles enters sleep at that edge. In sleep all gates are off, the flag reads not-ready, and any latched fault is cleared.
- R12: After reset release, and after `ctrlResetN` returns high from sleep, gates stay off and the flag reads not-ready for WAKE_CYC cycles. Normal operation then resumes.
- R13: `faultFlag` encoding is 2'b00 for running with no fault, 2'b01 for short fault latched, and 2'b10 for not ready (sleep or wake wait). Not ready takes priority. 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ctrlResetN | input | 1 | Pulse-qualified fault clear / sleep request, active low |
| pwmHi | input | 1 | Drive command |
| pwmLo | input | 1 | Recirculation command |
| syncRect | input | 1 | Synchronous rectification enable |
| shortDetectOff | input | 1 | Disables drain-source short detection |
| vdsFault | input | 4 | Per-FET drain-source comparator outputs |
| gateHs | output | 2 | High-side gate enables, bit i = leg i (0 = A) |
| gateLs | output | 2 | Low-side gate enables, bit i = leg i (0 = A) |
| faultFlag | output | 2 | Status code |

## Verification
The checker watches five properties on every cycle. No leg goes from its high-side FET on to its low-side FET on, or the reverse, in adjacent cycles. Held coast inputs leave every gate off. A not-ready or fault flag always coincides with all gates off. A disabled detector never latches a fault. The flag code 2'b11 never appears. The decode patterns, the exact length of the dead time and blanking windows, and the three outcomes of pulse-length qualification all depend on the stimulus history. The directed scenarios show those, counting cycles against the timing parameters.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } legSel_t;

  typedef enum logic [1:0] {
    MODE_WAKE  = 2'd0,
    MODE_RUN   = 2'd1,
    MODE_SLEEP = 2'd2
  } mode_t;

  typedef struct packed {
    logic driveEn;   // gates may be enabled
    logic detectEn;  // short detection armed
  } ctrlStrobe_t;

  localparam int NUM_LEGS = 2;
  localparam int NUM_FETS = 2 * NUM_LEGS;

  localparam logic [1:0] FLAG_OK       = 2'b00;
  localparam logic [1:0] FLAG_SHORT    = 2'b01;
  localparam logic [1:0] FLAG_NOTREADY = 2'b10;

endpackage

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    driveEn,
  input  legSel_t target,
  output logic    hsOn,
  output logic    lsOn
);

  localparam int CW = $clog2(DEAD_CYC + 1);

  legSel_t       applied;
  logic [CW-1:0] deadCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied <= LEG_OFF;
      deadCnt <= '0;
    end else if (!driveEn) begin
      applied <= LEG_OFF;
      deadCnt <= '0;
    end else if (deadCnt != '0) begin
      deadCnt <= deadCnt - CW'(1);
      if (deadCnt == CW'(1)) applied <= target;
    end else if (target != applied) begin
      applied <= LEG_OFF;
      if (target != LEG_OFF) deadCnt <= CW'(DEAD_CYC);
    end
  end

  assign hsOn = driveEn && (applied == LEG_HIGH);
  assign lsOn = driveEn && (applied == LEG_LOW);

endmodule

// File: rtl/hbg_path.sv
module hbg_path
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC  = 16,
  parameter int BLANK_CYC = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwmHi,
  input  logic                pwmLo,
  input  logic                syncRect,
  input  ctrlStrobe_t         strobe,
  input  logic [NUM_FETS-1:0] vdsFault,
  output logic [NUM_LEGS-1:0] gateHs,
  output logic [NUM_LEGS-1:0] gateLs,
  output logic                shortHit
);

  localparam int BW = $clog2(BLANK_CYC + 1);

  legSel_t             legTarget [NUM_LEGS];
  logic [NUM_FETS-1:0] fetOn;
  logic [NUM_FETS-1:0] fetHit;

  // leg 0 = A (sources in drive), leg 1 = B (sinks in drive)
  always_comb begin
    legTarget[0] = LEG_OFF;
    legTarget[1] = LEG_OFF;
    unique case ({pwmHi, pwmLo, syncRect})
      3'b110, 3'b111: begin legTarget[0] = LEG_HIGH; legTarget[1] = LEG_LOW;  end
      3'b011:         begin legTarget[0] = LEG_LOW;  legTarget[1] = LEG_LOW;  end
      3'b010:         begin legTarget[0] = LEG_OFF;  legTarget[1] = LEG_LOW;  end
      3'b101:         begin legTarget[0] = LEG_HIGH; legTarget[1] = LEG_HIGH; end
      3'b100:         begin legTarget[0] = LEG_HIGH; legTarget[1] = LEG_OFF;  end
      default:        begin legTarget[0] = LEG_OFF;  legTarget[1] = LEG_OFF;  end
    endcase
  end

  for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
    hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .driveEn (strobe.driveEn),
      .target  (legTarget[i]),
      .hsOn    (gateHs[i]),
      .lsOn    (gateLs[i])
    );
    assign fetOn[2*i]   = gateHs[i];
    assign fetOn[2*i+1] = gateLs[i];
  end

  for (genvar j = 0; j < NUM_FETS; j++) begin : g_blank
    logic [BW-1:0] blankCnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                blankCnt <= BW'(BLANK_CYC);
      else if (!fetOn[j])        blankCnt <= BW'(BLANK_CYC);
      else if (blankCnt != '0)   blankCnt <= blankCnt - BW'(1);
    end
    assign fetHit[j] = fetOn[j] && (blankCnt == '0) && vdsFault[j];
  end

  assign shortHit = strobe.detectEn && (|fetHit);

endmodule

// File: rtl/hbg_ctrl.sv
module hbg_ctrl
  import hbg_pkg::*;
#(
  parameter int CLEAR_MAX_CYC = 1000,
  parameter int SLEEP_CYC     = 50000,
  parameter int WAKE_CYC      = 300000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrlResetN,
  input  logic        shortDetectOff,
  input  logic        shortHit,
  output ctrlStrobe_t strobe,
  output logic [1:0]  faultFlag
);

  localparam int LW = $clog2(SLEEP_CYC + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);

  mode_t         mode;
  logic [LW-1:0] lowCnt;
  logic [WW-1:0] wakeCnt;
  logic          faultLatched;
  logic          sleepHit;
  logic          clearHit;

  assign sleepHit = !ctrlResetN && (lowCnt == LW'(SLEEP_CYC - 1));
  assign clearHit = ctrlResetN && (lowCnt != '0) && (lowCnt <= LW'(CLEAR_MAX_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           lowCnt <= '0;
    else if (!ctrlResetN) begin
      if (lowCnt != LW'(SLEEP_CYC))       lowCnt <= lowCnt + LW'(1);
    end else                              lowCnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_WAKE;
      wakeCnt <= WW'(WAKE_CYC);
    end else if (sleepHit) begin
      mode <= MODE_SLEEP;
    end else begin
      unique case (mode)
        MODE_SLEEP: if (ctrlResetN) begin
          mode    <= MODE_WAKE;
          wakeCnt <= WW'(WAKE_CYC);
        end
        MODE_WAKE: begin
          if (wakeCnt <= WW'(1)) mode <= MODE_RUN;
          else                   wakeCnt <= wakeCnt - WW'(1);
        end
        default: mode <= MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                faultLatched <= 1'b0;
    else if (sleepHit || clearHit)             faultLatched <= 1'b0;
    else if (mode == MODE_RUN && shortHit)     faultLatched <= 1'b1;
  end

  assign strobe.driveEn  = (mode == MODE_RUN) && !faultLatched;
  assign strobe.detectEn = (mode == MODE_RUN) && !shortDetectOff;

  always_comb begin
    if (mode != MODE_RUN)   faultFlag = FLAG_NOTREADY;
    else if (faultLatched)  faultFlag = FLAG_SHORT;
    else                    faultFlag = FLAG_OK;
  end

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int DEAD_CYC      = 16,
  parameter int BLANK_CYC     = 64,
  parameter int CLEAR_MAX_CYC = 1000,
  parameter int SLEEP_CYC     = 50000,
  parameter int WAKE_CYC      = 300000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrlResetN,
  input  logic       pwmHi,
  input  logic       pwmLo,
  input  logic       syncRect,
  input  logic       shortDetectOff,
  input  logic [3:0] vdsFault,
  output logic [1:0] gateHs,
  output logic [1:0] gateLs,
  output logic [1:0] faultFlag
);

  ctrlStrobe_t strobe;
  logic        shortHit;

  hbg_ctrl #(
    .CLEAR_MAX_CYC (CLEAR_MAX_CYC),
    .SLEEP_CYC     (SLEEP_CYC),
    .WAKE_CYC      (WAKE_CYC)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrlResetN     (ctrlResetN),
    .shortDetectOff (shortDetectOff),
    .shortHit       (shortHit),
    .strobe         (strobe),
    .faultFlag      (faultFlag)
  );

  hbg_path #(
    .DEAD_CYC  (DEAD_CYC),
    .BLANK_CYC (BLANK_CYC)
  ) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwmHi    (pwmHi),
    .pwmLo    (pwmLo),
    .syncRect (syncRect),
    .strobe   (strobe),
    .vdsFault (vdsFault),
    .gateHs   (gateHs),
    .gateLs   (gateLs),
    .shortHit (shortHit)
  );

endmodule

// File: rtl/hbridge_gate_seq_chk.sv
module hbridge_gate_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwmHi,
  input logic       pwmLo,
  input logic       shortDetectOff,
  input logic [1:0] gateHs,
  input logic [1:0] gateLs,
  input logic [1:0] faultFlag
);

  for (genvar i = 0; i < 2; i++) begin : g_leg
    // R6: a leg never switches directly between its two FETs
    a_r6_no_hs_to_ls: assert property (@(posedge clk) disable iff (!rst_n)
      gateHs[i] |=> !gateLs[i]);
    a_r6_no_ls_to_hs: assert property (@(posedge clk) disable iff (!rst_n)
      gateLs[i] |=> !gateHs[i]);
  end

  // R2: coast inputs sampled at an edge leave every gate off after it
  a_r2_coast_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwmHi && !pwmLo) |=> (gateHs == 2'b00 && gateLs == 2'b00));

  // R7, R11, R12: fault or not-ready status means no gate drive
  a_r12_flag_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    (faultFlag != 2'b00) |-> (gateHs == 2'b00 && gateLs == 2'b00));

  // R8: disabled detection never latches a short
  a_r8_detect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (faultFlag == 2'b00 && shortDetectOff) |=> (faultFlag != 2'b01));

  // R13: unused flag code
  a_r13_flag_legal: assert property (@(posedge clk) disable iff (!rst_n)
    faultFlag != 2'b11);

endmodule

bind hbridge_gate_seq hbridge_gate_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pwmHi          (pwmHi),
  .pwmLo          (pwmLo),
  .shortDetectOff (shortDetectOff),
  .gateHs         (gateHs),
  .gateLs         (gateLs),
  .faultFlag      (faultFlag)
);

// File: tb/hbridge_gate_seq_test.sv
module hbridge_gate_seq_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  DEAD   = 3;
  localparam int  BLANK  = 5;
  localparam int  CLRMAX = 4;
  localparam int  SLEEP  = 10;
  localparam int  WAKE   = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrlResetN = 1'b1;
  logic       pwmHi = 1'b0, pwmLo = 1'b0, syncRect = 1'b0;
  logic       shortDetectOff = 1'b0;
  logic [3:0] vdsFault = 4'b0000;
  logic [1:0] gateHs, gateLs, faultFlag;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hbridge_gate_seq #(
    .DEAD_CYC (DEAD), .BLANK_CYC (BLANK), .CLEAR_MAX_CYC (CLRMAX),
    .SLEEP_CYC (SLEEP), .WAKE_CYC (WAKE)
  ) uut (
    .clk (clk), .rst_n (rst_n), .ctrlResetN (ctrlResetN),
    .pwmHi (pwmHi), .pwmLo (pwmLo), .syncRect (syncRect),
    .shortDetectOff (shortDetectOff), .vdsFault (vdsFault),
    .gateHs (gateHs), .gateLs (gateLs), .faultFlag (faultFlag)
  );

  // gate vector in vdsFault bit order: {lsB, hsB, lsA, hsA}
  function automatic logic [3:0] gv();
    return {gateLs[1], gateHs[1], gateLs[0], gateHs[0]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkGates(input logic [3:0] exp, input string tag);
    check(gv() == exp, tag, int'(gv()), int'(exp));
  endtask

  task automatic checkFlag(input logic [1:0] exp, input string tag);
    check(faultFlag == exp, tag, int'(faultFlag), int'(exp));
  endtask

  task automatic setIn(input logic h, input logic l, input logic s);
    pwmHi = h; pwmLo = l; syncRect = s;
  endtask

  task automatic testPowerUp();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checkFlag(2'b10, "R12 flag after reset");
    checkGates(4'b0000, "R12 gates after reset");
    tick(WAKE - 1);
    checkFlag(2'b10, "R12 wake wait last cycle");
    tick(1);
    checkFlag(2'b00, "R13 running flag");
  endtask

  task automatic testDecode(input logic h, input logic l, input logic s,
                            input logic [3:0] exp, input string tag);
    setIn(1'b0, 1'b0, 1'b0);
    tick(DEAD + 2);
    setIn(h, l, s);
    tick(DEAD);
    checkGates(4'b0000, {tag, " R6 dead window"});
    tick(1);
    checkGates(exp, tag);
    tick(4);
    checkGates(exp, {tag, " held"});
  endtask

  task automatic testDeadTime();
    setIn(1'b1, 1'b1, 1'b0);
    tick(DEAD + 2);
    checkGates(4'b1001, "R1 drive before switch");
    setIn(1'b1, 1'b0, 1'b1);
    tick(1);
    checkGates(4'b0001, "R6 leg B off, leg A untouched");
    tick(DEAD - 1);
    checkGates(4'b0001, "R6 leg B still in dead time");
    tick(1);
    checkGates(4'b0101, "R6 leg B high after dead time");
  endtask

  task automatic testShortFault();
    setIn(1'b0, 1'b0, 1'b0);
    tick(DEAD + 2);
    vdsFault = 4'b1111;
    tick(3);
    checkFlag(2'b00, "R7 comparator ignored while off");
    setIn(1'b1, 1'b1, 1'b0);
    tick(DEAD + 1);
    checkGates(4'b1001, "R7 gates on at start of blanking");
    tick(BLANK);
    checkGates(4'b1001, "R7 still on through blanking");
    checkFlag(2'b00, "R7 no fault inside blanking");
    tick(1);
    checkFlag(2'b01, "R7 fault latched after blanking");
    checkGates(4'b0000, "R7 gates off on fault");
    vdsFault = 4'b0000;
  endtask

  task automatic testMidPulse();
    ctrlResetN = 1'b0;
    tick(CLRMAX + 2);
    ctrlResetN = 1'b1;
    tick(2);
    checkFlag(2'b01, "R10 mid-length pulse keeps fault");
    checkGates(4'b0000, "R10 gates stay off");
  endtask

  task automatic testShortPulse();
    ctrlResetN = 1'b0;
    tick(2);
    ctrlResetN = 1'b1;
    tick(1);
    checkFlag(2'b00, "R9 short pulse clears fault");
    tick(DEAD + 1);
    checkGates(4'b1001, "R9 drive resumes after clear");
  endtask

  task automatic testDetectOff();
    shortDetectOff = 1'b1;
    vdsFault = 4'b1111;
    tick(BLANK + 3);
    checkFlag(2'b00, "R8 no fault while detection off");
    checkGates(4'b1001, "R8 drive kept");
    vdsFault = 4'b0000;
    shortDetectOff = 1'b0;
    tick(1);
  endtask

  task automatic testSleep();
    vdsFault = 4'b0001;
    tick(2);
    checkFlag(2'b01, "R7 fault on expired blanking");
    vdsFault = 4'b0000;
    ctrlResetN = 1'b0;
    tick(SLEEP - 1);
    checkFlag(2'b01, "R11 not yet asleep");
    tick(1);
    checkFlag(2'b10, "R11 asleep");
    checkGates(4'b0000, "R11 gates off in sleep");
    tick(5);
    checkFlag(2'b10, "R11 sleep held");
    ctrlResetN = 1'b1;
    tick(WAKE);
    checkFlag(2'b10, "R12 wake wait after sleep");
    checkGates(4'b0000, "R12 gates off during wake");
    tick(1);
    checkFlag(2'b00, "R11 fault cleared by sleep");
    tick(DEAD + 1);
    checkGates(4'b1001, "R12 drive resumes after wake");
  endtask

  initial begin
    testPowerUp();
    testDecode(1'b1, 1'b1, 1'b0, 4'b1001, "R1 drive sr=0");
    testDecode(1'b1, 1'b1, 1'b1, 4'b1001, "R1 drive sr=1");
    testDecode(1'b0, 1'b0, 1'b1, 4'b0000, "R2 coast sr=1");
    testDecode(1'b0, 1'b1, 1'b1, 4'b1010, "R3 two-sided low brake");
    testDecode(1'b0, 1'b1, 1'b0, 4'b1000, "R4 one-sided low brake");
    testDecode(1'b1, 1'b0, 1'b1, 4'b0101, "R5 two-sided high brake");
    testDecode(1'b1, 1'b0, 1'b0, 4'b0001, "R5 one-sided high brake");
    setIn(1'b0, 1'b0, 1'b0);
    tick(1);
    checkGates(4'b0000, "R2 coast from brake");
    testDeadTime();
    testShortFault();
    testMidPulse();
    testShortPulse();
    testDetectOff();
    testSleep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule